// File: doc/BRIEF.md
# Latch-Pulse-Keyed Serial Command Interface

This block is the serial front end of an LED driver controller. Data enters on `sdi` and is shifted on every rising edge of the serial clock into a 16-bit input register. The top bit of that register is passed on to `sdo`, so several drivers can be chained.

Commands have no opcode field. The host holds `le` high for some number of rising clock edges, and that number selects the command. The command is decoded on the first rising edge at which `le` is seen low again. The block then raises one strobe for one cycle and presents, on `cmdData`, the 16-bit word that was in the input register at that moment. The block also holds the 16-bit configuration word. It can send that word, or a thermal status word, back on `sdo` through a separate output shift register.

Two configuration bits change the interface itself. Bit 13 moves `sdo` updates to the falling clock edge. Bit 10 enables an automatic sleep state, entered when the channel-switch word is all zeros. In that state the block accepts only a channel-switch word that turns at least one channel on.

Top module: `lpk_serial_if`

## Requirements
- R1: Each rising edge of `clk` shifts `sdi` into bit 0 of the 16-bit input register. While no readout is in progress, `sdo` carries bit 15 of that register, so a word shifted in MSB first appears on `sdo` MSB first over the next 16 edges.
- R2: The number of rising edges at which `le` is high selects the strobe bit on `cmdStrobe`:
  - 1–2: bit 0, switch write.
  - 3–4: bit 1, data latch.
  - 5–6: bit 2, global latch.
  - 7: bit 3, configuration write.
  - 8: bit 4, configuration read.
  - 9: bit 5, open test start.
  - 10: bit 6, short test start.
  - 11: bit 7, combined test start.
  - 12: bit 8, test end.
  - 13: bit 9, thermal read.
  - 0 or 14 and more: no strobe.
- R3: A strobe is high for exactly one cycle, after the first rising edge at which `le` is sampled low. With every strobe, `cmdData` takes the input register contents as they stood before that edge. The last bit sampled while `le` was high lands in bit 0.
- R4: `cfgWord` resets to all zeros and takes `cmdData`'s word on an accepted configuration write. No other event changes it.
- R5: After an accepted configuration read, `sdo` presents `cfgWord` bits 15 down to 0, one bit per clock. Bit 15 is valid after the decoding edge. After 16 bits, `sdo` returns to the chain path.
- R6: After an accepted thermal read, `sdo` presents 16 copies of `overTemp`, sampled at the decoding edge, in the same 16-clock window as R5.
- R7: With `cfgWord` bit 13 set, `sdo` changes only on falling edges of `clk` and shows the value it would have shown after the preceding rising edge. With bit 13 clear, `sdo` changes right after the rising edge.
- R8: An accepted switch write sets `powerDown` when `cfgWord` bit 10 is 1 and the word is zero, and clears `powerDown` otherwise. While `powerDown` is set, every key is ignored, with no strobe and no change to `cfgWord` or `cmdData`. The one exception is a switch write with a nonzero word, which is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Latch/key line; its high-edge count selects the command |
| overTemp | input | 1 | Over-temperature flag reported by the thermal read |
| sdo | output | 1 | Serial data out (chain or readout) |
| cmdStrobe | output | 10 | One-hot command strobes, one cycle wide |
| cmdData | output | 16 | Word captured with the last accepted command |
| cfgWord | output | 16 | Configuration register |
| powerDown | output | 1 | Automatic sleep state is active |

## Verification
Every key length from 0 to 16 edges is sent with distinct payloads. This shows the edge-count boundaries between neighbouring commands, and shows that the reserved and empty counts issue nothing. Seeded random words, key lengths and thermal flags then run against a bench model of the configuration and sleep state. This mixes writes and reads in orders the directed part does not reach. Readouts are sampled both just after the rising edge and after the falling edge, which tells the two `sdo` timing modes apart. A fixed sequence enters sleep, then tries a configuration write, a thermal read and a zero switch word before waking. This shows which commands the sleep state blocks and which one ends it.

// File: rtl/lpk_pkg.sv
package lpk_pkg;
  localparam int KCNT_W = 5;
  localparam int CMD_N  = 10;

  // strobe bit positions
  localparam int CMD_SWITCH = 0;
  localparam int CMD_DLATCH = 1;
  localparam int CMD_GLATCH = 2;
  localparam int CMD_WCFG   = 3;
  localparam int CMD_RCFG   = 4;
  localparam int CMD_OPEN   = 5;
  localparam int CMD_SHORT  = 6;
  localparam int CMD_COMB   = 7;
  localparam int CMD_DEND   = 8;
  localparam int CMD_THERM  = 9;

  // configuration bits used by this block
  localparam int CFG_AUTOOFF_BIT = 10;
  localparam int CFG_SDOFALL_BIT = 13;

  typedef logic [CMD_N-1:0] cmdVec_t;

  typedef struct packed {
    logic capture;
    logic loadCfg;
    logic loadRead;
    logic loadThermal;
  } dpCtl_t;

  // edge count while the latch line was high -> one-hot command
  function automatic cmdVec_t keyDecode(input logic [KCNT_W-1:0] n);
    cmdVec_t v;
    v = '0;
    case (n)
      5'd1, 5'd2: v[CMD_SWITCH] = 1'b1;
      5'd3, 5'd4: v[CMD_DLATCH] = 1'b1;
      5'd5, 5'd6: v[CMD_GLATCH] = 1'b1;
      5'd7:       v[CMD_WCFG]   = 1'b1;
      5'd8:       v[CMD_RCFG]   = 1'b1;
      5'd9:       v[CMD_OPEN]   = 1'b1;
      5'd10:      v[CMD_SHORT]  = 1'b1;
      5'd11:      v[CMD_COMB]   = 1'b1;
      5'd12:      v[CMD_DEND]   = 1'b1;
      5'd13:      v[CMD_THERM]  = 1'b1;
      default:    v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/lpk_ctrl.sv
module lpk_ctrl
  import lpk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    le,
  input  logic    wordZero,
  input  logic    autoOffEn,
  output dpCtl_t  ctl,
  output cmdVec_t strobe,
  output logic    pwrDown
);
  localparam logic [KCNT_W-1:0] KMAX = {KCNT_W{1'b1}};

  logic [KCNT_W-1:0] leCnt;
  logic              keyEnd;
  cmdVec_t           rawCmd;
  cmdVec_t           granted;

  assign keyEnd = !le && (leCnt != '0);

  always_comb begin
    rawCmd = keyEnd ? keyDecode(leCnt) : '0;
    granted = rawCmd;
    if (pwrDown) begin
      granted = '0;
      granted[CMD_SWITCH] = rawCmd[CMD_SWITCH] && !wordZero;
    end
  end

  always_comb begin
    ctl.capture     = |granted;
    ctl.loadCfg     = granted[CMD_WCFG];
    ctl.loadRead    = granted[CMD_RCFG];
    ctl.loadThermal = granted[CMD_THERM];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leCnt   <= '0;
      strobe  <= '0;
      pwrDown <= 1'b0;
    end else begin
      if (le) begin
        if (leCnt != KMAX) leCnt <= leCnt + 1'b1;
      end else begin
        leCnt <= '0;
      end
      strobe <= granted;
      if (granted[CMD_SWITCH]) pwrDown <= autoOffEn && wordZero;
    end
  end

  // R2: never more than one command at a time
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R3: a strobe lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe) |=> (strobe == '0));

  // R3: a strobe follows a high-then-low latch line
  a_r3_key_edge: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe) |-> (!$past(le) && $past(le, 2)));

  // R8: while asleep only the switch strobe can appear
  a_r8_sleep_gate: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> (strobe[CMD_N-1:1] == '0));
endmodule

// File: rtl/lpk_datapath.sv
module lpk_datapath
  import lpk_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  logic              overTemp,
  input  dpCtl_t            ctl,
  output logic              sdo,
  output logic [WORD_W-1:0] cmdData,
  output logic [WORD_W-1:0] cfgWord,
  output logic              wordZero
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] outReg;
  logic [CNT_W-1:0]  outCnt;
  logic              sdoRise;
  logic              sdoFall;

  assign wordZero = (shiftReg == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      cmdData  <= '0;
      cfgWord  <= '0;
      outReg   <= '0;
      outCnt   <= '0;
    end else begin
      shiftReg <= {shiftReg[WORD_W-2:0], sdi};
      if (ctl.capture) cmdData <= shiftReg;
      if (ctl.loadCfg) cfgWord <= shiftReg;
      if (ctl.loadRead) begin
        outReg <= cfgWord;
        outCnt <= CNT_W'(WORD_W);
      end else if (ctl.loadThermal) begin
        outReg <= {WORD_W{overTemp}};
        outCnt <= CNT_W'(WORD_W);
      end else if (outCnt != '0) begin
        outReg <= {outReg[WORD_W-2:0], 1'b0};
        outCnt <= outCnt - 1'b1;
      end
    end
  end

  assign sdoRise = (outCnt != '0) ? outReg[WORD_W-1] : shiftReg[WORD_W-1];

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) sdoFall <= 1'b0;
    else       sdoFall <= sdoRise;
  end

  assign sdo = cfgWord[CFG_SDOFALL_BIT] ? sdoFall : sdoRise;

  // R4: configuration changes only on an accepted write
  a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadCfg |=> $stable(cfgWord));

  // R5: readout window never exceeds one word
  a_r5_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    outCnt <= CNT_W'(WORD_W));

  // R5: readout register holds the configuration after a read
  a_r5_read_load: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadRead |=> (outReg == $past(cfgWord)));

  // R6: thermal word is uniform
  a_r6_thermal_fill: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadThermal |=> (outReg == '0 || outReg == '1));
endmodule

// File: rtl/lpk_serial_if.sv
module lpk_serial_if
  import lpk_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  logic              le,
  input  logic              overTemp,
  output logic              sdo,
  output logic [CMD_N-1:0]  cmdStrobe,
  output logic [WORD_W-1:0] cmdData,
  output logic [WORD_W-1:0] cfgWord,
  output logic              powerDown
);
  dpCtl_t ctl;
  logic   wordZero;

  lpk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .le        (le),
    .wordZero  (wordZero),
    .autoOffEn (cfgWord[CFG_AUTOOFF_BIT]),
    .ctl       (ctl),
    .strobe    (cmdStrobe),
    .pwrDown   (powerDown)
  );

  lpk_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sdi      (sdi),
    .overTemp (overTemp),
    .ctl      (ctl),
    .sdo      (sdo),
    .cmdData  (cmdData),
    .cfgWord  (cfgWord),
    .wordZero (wordZero)
  );
endmodule

// File: tb/lpk_serial_if_tb.sv
module lpk_serial_if_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sdi = 1'b0;
  logic        le = 1'b0;
  logic        overTemp = 1'b0;
  logic        sdo;
  logic [9:0]  cmdStrobe;
  logic [15:0] cmdData;
  logic [15:0] cfgWord;
  logic        powerDown;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic [15:0] expCfg = '0;
  logic [15:0] expData = '0;
  logic        expPd = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  lpk_serial_if u_dut (
    .clk(clk), .rstN(rstN), .sdi(sdi), .le(le), .overTemp(overTemp),
    .sdo(sdo), .cmdStrobe(cmdStrobe), .cmdData(cmdData),
    .cfgWord(cfgWord), .powerDown(powerDown)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R2 key map from the requirement
  function automatic logic [9:0] expStrobe(input int k);
    logic [9:0] v;
    v = '0;
    case (k)
      1, 2:  v[0] = 1'b1;
      3, 4:  v[1] = 1'b1;
      5, 6:  v[2] = 1'b1;
      7:     v[3] = 1'b1;
      8:     v[4] = 1'b1;
      9:     v[5] = 1'b1;
      10:    v[6] = 1'b1;
      11:    v[7] = 1'b1;
      12:    v[8] = 1'b1;
      13:    v[9] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic sendKey(input logic [15:0] w, input int k);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk); sdi = w[i]; le = (i < k);
    end
    @(negedge clk); sdi = 1'b0; le = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic readOut(input logic [15:0] exp, input bit fallMode, input string req);
    for (int j = 15; j >= 0; j--) begin
      if (j < 15) begin
        @(posedge clk); #1;
        // R7: just after the rising edge
        if (fallMode) chk(sdo == exp[j+1], "R7", 32'(sdo), 32'(exp[j+1]));
        else          chk(sdo == exp[j],   "R7", 32'(sdo), 32'(exp[j]));
      end
      @(negedge clk); #1;
      chk(sdo == exp[j], req, 32'(sdo), 32'(exp[j]));
    end
  endtask

  task automatic doKey(input logic [15:0] w, input int k);
    logic [9:0] e;
    logic       ot;
    ot = overTemp;
    sendKey(w, k);
    e = expStrobe(k);
    if (expPd) e = (e[0] && w != 16'h0) ? 10'h001 : 10'h000;
    chk(cmdStrobe == e, "R2", 32'(cmdStrobe), 32'(e));
    if (e != '0) expData = w;
    chk(cmdData == expData, "R3", 32'(cmdData), 32'(expData));
    if (e[3]) expCfg = w;
    if (e[0]) expPd = expCfg[10] && (w == 16'h0);
    chk(cfgWord == expCfg, "R4", 32'(cfgWord), 32'(expCfg));
    chk(powerDown == expPd, "R8", 32'(powerDown), 32'(expPd));
    if (e[4]) readOut(expCfg, expCfg[13], "R5");
    if (e[9]) readOut({16{ot}}, expCfg[13], "R6");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // reset state
    chk(cfgWord == 16'h0, "R4", 32'(cfgWord), 0);
    chk(cmdStrobe == '0, "R2", 32'(cmdStrobe), 0);
    chk(powerDown == 1'b0, "R8", 32'(powerDown), 0);
    chk(sdo == 1'b0, "R1", 32'(sdo), 0);

    // R1: chain path
    w = 16'hA5C3;
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk); sdi = w[i]; le = 1'b0;
    end
    @(negedge clk); sdi = 1'b0;
    for (int j = 15; j >= 0; j--) begin
      #1 chk(sdo == w[j], "R1", 32'(sdo), 32'(w[j]));
      @(negedge clk);
    end

    // R2/R3: every key length
    overTemp = 1'b1;
    for (int k = 0; k <= 16; k++) doKey(16'h0120 + 16'(k), k);

    // R3: strobe drops after one cycle
    sendKey(16'h0F0F, 3);
    @(posedge clk); #1;
    chk(cmdStrobe == '0, "R3", 32'(cmdStrobe), 0);
    expData = 16'h0F0F;

    // R7: falling-edge readout of configuration and thermal status
    doKey(16'h2000, 7);
    doKey(16'h0000, 8);
    overTemp = 1'b0;
    doKey(16'h0000, 13);
    overTemp = 1'b1;
    doKey(16'h0000, 13);
    doKey(16'h0000, 7);

    // R8: sleep entry, blocked keys, wake
    doKey(16'h0400, 7);
    doKey(16'h0000, 1);
    chk(powerDown == 1'b1, "R8", 32'(powerDown), 1);
    doKey(16'h1234, 7);
    doKey(16'h0000, 13);
    doKey(16'h0000, 2);
    doKey(16'h8001, 2);
    chk(powerDown == 1'b0, "R8", 32'(powerDown), 0);
    doKey(16'h0000, 7);

    // random mix
    for (int n = 0; n < 80; n++) begin
      overTemp = 1'($urandom % 2);
      w = 16'($urandom);
      if (($urandom % 8) == 0) w = 16'h0;
      doKey(w, int'($urandom % 17));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule